// File: doc/BRIEF.md
# Edge/Level Interrupt Request Tracker

This block sits inside an interrupt router and decides, pin by pin, when an interrupt leaves for the local interrupt controllers. For every pin it holds a pending-request flag (IRR). Level-triggered entries also carry a remote-IRR flag, and edge-triggered entries carry a delivered flag. The source side reports each pin's line level with an update strobe. Software-side logic rewrites a pin's routing entry through a one-entry-per-cycle write port. Returning end-of-interrupt messages arrive with their vector.

Each cycle, a fixed-priority picker takes the pins that are ready and blocked by nothing. It picks the lowest index. The chosen entry's routing fields are registered onto a single-cycle delivery request. The receiving side answers in that same cycle on `dlv_accepted`. An accepted level-triggered delivery holds its pin off until an end-of-interrupt with a matching vector arrives. Destination matching and arbitration among processors happen elsewhere.

Top module: `irt_tracker`

## Requirements
- R1: After reset every entry is masked (trigger field 0 = edge, mask field 1), `dlv_valid` is low, and a high update on any pin produces no delivery.
- R2: A pin update with level 0 clears that pin's IRR. A later end-of-interrupt for its vector then produces no delivery.
- R3: A high update on an edge-triggered pin whose IRR is already set is coalesced and produces no delivery. After a low update, the next high update is delivered again.
- R4: A masked entry is never delivered. A request made while the entry is masked is dropped.
- R5: A level-triggered entry whose remote-IRR is set is not delivered, even on a new high update.
- R6: A level-triggered delivery sets the entry's remote-IRR only if `dlv_accepted` is high in the cycle `dlv_valid` is high. If it is not accepted, the next high update is delivered.
- R7: An end-of-interrupt whose vector equals a level-triggered entry's vector clears its remote-IRR. If that entry is unmasked and its IRR is still set, it is delivered two clock edges after the end-of-interrupt is sampled.
- R8: An end-of-interrupt acts on every entry whose vector matches, not only the first.
- R9: A routing write that leaves a level-triggered entry unmasked, with IRR set and remote-IRR clear, delivers it three clock edges after the write is sampled.
- R10: An edge-triggered entry is delivered at most once per accepted request. A matching end-of-interrupt or a rewrite of the entry does not deliver it again.
- R11: When several pins are ready in the same cycle, exactly one is granted per cycle, lowest index first.
- R12: A high update that is not blocked yields `dlv_valid` two clock edges after it is sampled. The request carries the entry's vector, destination, destination mode, delivery mode and trigger mode.
- R13: Writing an entry as edge-triggered clears its remote-IRR. A later rewrite back to unmasked level-triggered then delivers the still-pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_upd | input | NPINS | Per-pin strobe: the line level is reported this cycle |
| line_lvl | input | NPINS | Per-pin line level, read when the strobe is high |
| cfg_we | input | 1 | Write one routing entry |
| cfg_pin | input | PIN_W | Entry index for the write |
| cfg_vector | input | 8 | Vector field |
| cfg_dest | input | 8 | Destination field |
| cfg_dest_logical | input | 1 | Destination mode: 1 logical, 0 physical |
| cfg_dmode | input | 3 | Delivery mode field |
| cfg_level | input | 1 | Trigger mode: 1 level, 0 edge |
| cfg_mask | input | 1 | 1 masks the entry |
| eoi_valid | input | 1 | End-of-interrupt message present |
| eoi_vector | input | 8 | Vector of the end-of-interrupt |
| dlv_accepted | input | 1 | At least one destination took the current request |
| dlv_valid | output | 1 | Delivery request, one cycle per delivery |
| dlv_vector | output | 8 | Vector of the request |
| dlv_dest | output | 8 | Destination of the request |
| dlv_dest_logical | output | 1 | Destination mode of the request |
| dlv_dmode | output | 3 | Delivery mode of the request |
| dlv_level | output | 1 | Trigger mode of the request |

## Verification
Line updates and end-of-interrupt messages show up on `dlv_valid` two clock edges after they are sampled: one edge sets the pending flag and one registers the grant. A routing write needs three edges, because its re-evaluation pulse is registered behind the table update. An acceptance takes effect at the edge that samples it. The bench drives inputs just after a falling edge. Each expected result is read at the falling edge that follows the due rising edge, and the cycle in between is also checked for silence. A behavioural model in the bench steps on every rising edge and is compared with all delivery outputs at every falling edge. This also covers back-to-back grants.

// File: rtl/irt_pkg.sv
// Shared types for the interrupt request tracker.
// Assumes: vector, destination and delivery-mode widths are fixed chip-wide.
package irt_pkg;
    localparam int VEC_W   = 8;
    localparam int DST_W   = 8;
    localparam int DMODE_W = 3;

    // One routing entry as held in the table.
    typedef struct packed {
        logic [VEC_W-1:0]   vector;
        logic [DST_W-1:0]   dest;
        logic               dest_logical;
        logic [DMODE_W-1:0] dmode;
        logic               level_trig;
        logic               masked;
    } route_t;

    localparam route_t ROUTE_RESET = '{
        vector: '0, dest: '0, dest_logical: 1'b0,
        dmode: '0, level_trig: 1'b0, masked: 1'b1
    };
endpackage

// File: rtl/irt_route_table.sv
// Routing table: one entry per pin, one write per cycle.
// Also emits a registered one-hot pulse, the cycle after a write, naming the
// entry that changed so the pin cell can re-evaluate against the new value.
// Assumes: wr_pin is always below NPINS.
module irt_route_table
    import irt_pkg::*;
#(
    parameter int NPINS = 8,
    parameter int PIN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PIN_W-1:0] wr_pin,
    input  route_t           wr_data,
    output route_t           table_o [NPINS],
    output logic [NPINS-1:0] wr_done
);
    for (genvar p = 0; p < NPINS; p++) begin : g_ent
        // Hold entry p; reset leaves it masked.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                table_o[p] <= ROUTE_RESET;
                wr_done[p] <= 1'b0;
            end else begin
                wr_done[p] <= wr_en && (wr_pin == PIN_W'(p));
                if (wr_en && (wr_pin == PIN_W'(p)))
                    table_o[p] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/irt_pin_cell.sv
// Per-pin request state: IRR, remote-IRR, edge delivered flag and a
// pending-service flag. Reports ready when a pending service is not blocked.
// Assumes: grant only when ready; inflight/accept refer to the request now
// on the delivery output.
module irt_pin_cell
    import irt_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   upd,
    input  logic   lvl,
    input  route_t ent,
    input  logic   eoi_hit,
    input  logic   wr_done,
    input  logic   grant,
    input  logic   inflight,
    input  logic   accept,
    output logic   ready
);
    logic irr_q, rirr_q, dlvd_q, pend_q;
    logic req_hi, req_lo, coalesce, blocked, eoi_redo, wr_redo;

    // Classify this cycle's events and decide whether the pin may go out.
    always_comb begin
        req_hi   = upd && lvl;
        req_lo   = upd && !lvl;
        coalesce = req_hi && !ent.level_trig && irr_q;
        blocked  = ent.masked || !irr_q
                || (ent.level_trig && (rirr_q || inflight))
                || (!ent.level_trig && dlvd_q);
        ready    = pend_q && !blocked;
        eoi_redo = eoi_hit && ent.level_trig && !ent.masked && irr_q;
        wr_redo  = wr_done && ent.level_trig && !ent.masked && irr_q && !rirr_q;
    end

    // Advance the four state flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q  <= 1'b0;
            rirr_q <= 1'b0;
            dlvd_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            irr_q  <= req_lo ? 1'b0 : (req_hi ? 1'b1 : irr_q);
            rirr_q <= ent.level_trig && ((rirr_q && !eoi_hit) || accept);
            dlvd_q <= !ent.level_trig && ((dlvd_q || grant) && !req_hi);
            pend_q <= (pend_q && !grant && !blocked)
                   || (req_hi && !coalesce) || eoi_redo || wr_redo;
        end
    end
endmodule

// File: rtl/irt_prio_pick.sv
// Fixed-priority picker: grants the lowest-index request.
// Assumes: IW is wide enough to index N.
module irt_prio_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Scan downward so the lowest set request is the last one kept.
    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = IW'(i);
            end
        end
        any = |req;
    end
endmodule

// File: rtl/irt_tracker.sv
// Edge/level interrupt request tracker top.
// Holds the routing table and per-pin request state, picks one ready pin per
// cycle and registers its routing fields onto the delivery request.
// Assumes: dlv_accepted is answered in the same cycle dlv_valid is high.
module irt_tracker
    import irt_pkg::*;
#(
    parameter int NPINS = 8,
    localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NPINS-1:0]   line_upd,
    input  logic [NPINS-1:0]   line_lvl,
    input  logic               cfg_we,
    input  logic [PIN_W-1:0]   cfg_pin,
    input  logic [VEC_W-1:0]   cfg_vector,
    input  logic [DST_W-1:0]   cfg_dest,
    input  logic               cfg_dest_logical,
    input  logic [DMODE_W-1:0] cfg_dmode,
    input  logic               cfg_level,
    input  logic               cfg_mask,
    input  logic               eoi_valid,
    input  logic [VEC_W-1:0]   eoi_vector,
    input  logic               dlv_accepted,
    output logic               dlv_valid,
    output logic [VEC_W-1:0]   dlv_vector,
    output logic [DST_W-1:0]   dlv_dest,
    output logic               dlv_dest_logical,
    output logic [DMODE_W-1:0] dlv_dmode,
    output logic               dlv_level
);
    route_t             cfg_word;
    route_t             tbl [NPINS];
    logic [NPINS-1:0]   wr_done;
    logic [NPINS-1:0]   eoi_hit, inflight_vec, accept_vec;
    logic [NPINS-1:0]   ready_vec, grant_vec, mask_vec;
    logic [PIN_W-1:0]   grant_idx;
    logic               grant_any;
    logic [PIN_W-1:0]   dlv_pin_q;

    // Pack the write-port fields into one entry.
    always_comb begin
        cfg_word = '{vector: cfg_vector, dest: cfg_dest,
                     dest_logical: cfg_dest_logical, dmode: cfg_dmode,
                     level_trig: cfg_level, masked: cfg_mask};
    end

    irt_route_table #(.NPINS(NPINS), .PIN_W(PIN_W)) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_pin(cfg_pin),
        .wr_data(cfg_word), .table_o(tbl), .wr_done(wr_done)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        // Per-pin decode of end-of-interrupt and of the request in flight.
        always_comb begin
            eoi_hit[p]      = eoi_valid && (tbl[p].vector == eoi_vector);
            inflight_vec[p] = dlv_valid && (dlv_pin_q == PIN_W'(p));
            accept_vec[p]   = inflight_vec[p] && dlv_accepted;
            mask_vec[p]     = tbl[p].masked;
        end

        irt_pin_cell u_cell (
            .clk(clk), .rst_n(rst_n), .upd(line_upd[p]), .lvl(line_lvl[p]),
            .ent(tbl[p]), .eoi_hit(eoi_hit[p]), .wr_done(wr_done[p]),
            .grant(grant_vec[p]), .inflight(inflight_vec[p]),
            .accept(accept_vec[p]), .ready(ready_vec[p])
        );
    end

    irt_prio_pick #(.N(NPINS), .IW(PIN_W)) u_pick (
        .req(ready_vec), .grant(grant_vec), .idx(grant_idx), .any(grant_any)
    );

    // Register the granted entry onto the delivery request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dlv_valid        <= 1'b0;
            dlv_pin_q        <= '0;
            dlv_vector       <= '0;
            dlv_dest         <= '0;
            dlv_dest_logical <= 1'b0;
            dlv_dmode        <= '0;
            dlv_level        <= 1'b0;
        end else begin
            dlv_valid <= grant_any;
            if (grant_any) begin
                dlv_pin_q        <= grant_idx;
                dlv_vector       <= tbl[grant_idx].vector;
                dlv_dest         <= tbl[grant_idx].dest;
                dlv_dest_logical <= tbl[grant_idx].dest_logical;
                dlv_dmode        <= tbl[grant_idx].dmode;
                dlv_level        <= tbl[grant_idx].level_trig;
            end
        end
    end
endmodule

// File: rtl/irt_tracker_chk.sv
// Property checker for irt_tracker, attached by bind below.
module irt_tracker_chk #(
    parameter int NPINS = 8,
    parameter int PIN_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] grant_vec,
    input logic [NPINS-1:0] ready_vec,
    input logic [NPINS-1:0] mask_vec,
    input logic             dlv_valid,
    input logic             dlv_level,
    input logic             dlv_accepted,
    input logic [PIN_W-1:0] dlv_pin_q
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !dlv_valid); // R1
    AST_MASKED_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vec & mask_vec) == '0); // R4
    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && dlv_level && dlv_accepted)
        |=> !(dlv_valid && dlv_pin_q == $past(dlv_pin_q))); // R5
    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec) && ((grant_vec & ~ready_vec) == '0)); // R11
    AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vec != '0) |-> (((grant_vec - NPINS'(1)) & ready_vec) == '0)); // R11
    AST_GRANT_TO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vec != '0) |=> dlv_valid); // R12
endmodule

bind irt_tracker irt_tracker_chk #(.NPINS(NPINS), .PIN_W(PIN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .grant_vec(grant_vec), .ready_vec(ready_vec),
    .mask_vec(mask_vec), .dlv_valid(dlv_valid), .dlv_level(dlv_level),
    .dlv_accepted(dlv_accepted), .dlv_pin_q(dlv_pin_q)
);

// File: tb/irt_tracker_test.sv
module irt_tracker_test;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] line_upd = '0;
    logic [N-1:0] line_lvl = '0;
    logic         cfg_we = 1'b0;
    logic [2:0]   cfg_pin = '0;
    logic [7:0]   cfg_vector = '0;
    logic [7:0]   cfg_dest = '0;
    logic         cfg_dest_logical = 1'b0;
    logic [2:0]   cfg_dmode = '0;
    logic         cfg_level = 1'b0;
    logic         cfg_mask = 1'b1;
    logic         eoi_valid = 1'b0;
    logic [7:0]   eoi_vector = '0;
    logic         dlv_accepted = 1'b1;
    logic         dlv_valid;
    logic [7:0]   dlv_vector;
    logic [7:0]   dlv_dest;
    logic         dlv_dest_logical;
    logic [2:0]   dlv_dmode;
    logic         dlv_level;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irt_tracker #(.NPINS(N)) uut (
        .clk(clk), .rst_n(rst_n), .line_upd(line_upd), .line_lvl(line_lvl),
        .cfg_we(cfg_we), .cfg_pin(cfg_pin), .cfg_vector(cfg_vector),
        .cfg_dest(cfg_dest), .cfg_dest_logical(cfg_dest_logical),
        .cfg_dmode(cfg_dmode), .cfg_level(cfg_level), .cfg_mask(cfg_mask),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .dlv_accepted(dlv_accepted), .dlv_valid(dlv_valid),
        .dlv_vector(dlv_vector), .dlv_dest(dlv_dest),
        .dlv_dest_logical(dlv_dest_logical), .dlv_dmode(dlv_dmode),
        .dlv_level(dlv_level)
    );

    // ---------------- behavioural reference model ----------------
    int m_vec [N], m_dst [N], m_dm [N];
    bit m_log [N], m_lt [N], m_msk [N];
    bit m_irr [N], m_rirr [N], m_dl [N], m_pend [N], m_wr [N];
    bit n_irr [N], n_rirr [N], n_dl [N], n_pend [N], blk [N];
    bit e_valid = 1'b0;
    int e_pin = 0, e_vec = 0, e_dst = 0, e_dm = 0;
    bit e_log = 1'b0, e_lt = 1'b0;
    int g;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_vec[i] = 0; m_dst[i] = 0; m_dm[i] = 0; m_log[i] = 0;
                m_lt[i] = 0; m_msk[i] = 1; m_irr[i] = 0; m_rirr[i] = 0;
                m_dl[i] = 0; m_pend[i] = 0; m_wr[i] = 0;
            end
            e_valid = 0; e_pin = 0; e_vec = 0; e_dst = 0; e_dm = 0;
            e_log = 0; e_lt = 0;
        end else begin
            g = -1;
            for (int i = 0; i < N; i++) begin
                blk[i] = m_msk[i] || !m_irr[i]
                      || (m_lt[i] && (m_rirr[i] || (e_valid && e_pin == i)))
                      || (!m_lt[i] && m_dl[i]);
                if (g < 0 && m_pend[i] && !blk[i]) g = i;
            end
            for (int i = 0; i < N; i++) begin
                bit hi, lo, co, eh;
                hi = line_upd[i] && line_lvl[i];
                lo = line_upd[i] && !line_lvl[i];
                co = hi && !m_lt[i] && m_irr[i];
                eh = eoi_valid && (eoi_vector == 8'(m_vec[i]));
                n_pend[i] = (m_pend[i] && g != i && !blk[i]) || (hi && !co)
                         || (eh && m_lt[i] && !m_msk[i] && m_irr[i])
                         || (m_wr[i] && m_lt[i] && !m_msk[i] && m_irr[i] && !m_rirr[i]);
                n_rirr[i] = m_lt[i] && ((m_rirr[i] && !eh)
                         || (e_valid && e_pin == i && dlv_accepted));
                n_dl[i] = !m_lt[i] && ((m_dl[i] || g == i) && !hi);
                n_irr[i] = lo ? 1'b0 : (hi ? 1'b1 : m_irr[i]);
            end
            if (g >= 0) begin
                e_valid = 1; e_pin = g; e_vec = m_vec[g]; e_dst = m_dst[g];
                e_log = m_log[g]; e_dm = m_dm[g]; e_lt = m_lt[g];
            end else begin
                e_valid = 0;
            end
            for (int i = 0; i < N; i++) begin
                m_irr[i] = n_irr[i]; m_rirr[i] = n_rirr[i];
                m_dl[i] = n_dl[i]; m_pend[i] = n_pend[i];
                m_wr[i] = cfg_we && (int'(cfg_pin) == i);
                if (m_wr[i]) begin
                    m_vec[i] = int'(cfg_vector); m_dst[i] = int'(cfg_dest);
                    m_log[i] = cfg_dest_logical; m_dm[i] = int'(cfg_dmode);
                    m_lt[i] = cfg_level; m_msk[i] = cfg_mask;
                end
            end
        end
    end

    // Compare every delivery output with the model on each falling edge (R12).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (dlv_valid !== e_valid ||
                (e_valid && (dlv_vector !== 8'(e_vec) || dlv_dest !== 8'(e_dst) ||
                 dlv_dest_logical !== e_log || dlv_dmode !== 3'(e_dm) ||
                 dlv_level !== e_lt))) begin
                failures++;
                $display("FAIL R12 model t=%0t actual v=%0b vec=%h dst=%h lg=%0b dm=%0d lt=%0b expected v=%0b vec=%h dst=%h lg=%0b dm=%0d lt=%0b",
                         $time, dlv_valid, dlv_vector, dlv_dest, dlv_dest_logical,
                         dlv_dmode, dlv_level, e_valid, e_vec[7:0], e_dst[7:0],
                         e_log, e_dm, e_lt);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic expect_dlv(input logic [7:0] vec, input logic [7:0] dst, input string req);
        checks++;
        if (!(dlv_valid === 1'b1 && dlv_vector === vec && dlv_dest === dst)) begin
            failures++;
            $display("FAIL %s actual valid=%0b vec=%h dst=%h expected valid=1 vec=%h dst=%h",
                     req, dlv_valid, dlv_vector, dlv_dest, vec, dst);
        end
    endtask

    task automatic expect_idle(input string req);
        checks++;
        if (dlv_valid !== 1'b0) begin
            failures++;
            $display("FAIL %s actual valid=%0b vec=%h expected valid=0", req, dlv_valid, dlv_vector);
        end
    endtask

    task automatic set_route(input int pin, input logic [7:0] vec, input logic [7:0] dst,
                             input logic lg, input logic [2:0] dm, input logic lv, input logic mk);
        cfg_we = 1'b1; cfg_pin = 3'(pin); cfg_vector = vec; cfg_dest = dst;
        cfg_dest_logical = lg; cfg_dmode = dm; cfg_level = lv; cfg_mask = mk;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic line(input int pin, input logic val);
        line_upd[pin] = 1'b1; line_lvl[pin] = val;
        tick();
        line_upd = '0;
    endtask

    task automatic send_eoi(input logic [7:0] vec);
        eoi_valid = 1'b1; eoi_vector = vec;
        tick();
        eoi_valid = 1'b0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        repeat (4) tick();
        rst_n = 1'b1;
        tick();
        expect_idle("R1 reset");
        // R1: masked after reset, a high update goes nowhere
        line(0, 1'b1); tick(); expect_idle("R1 masked at reset");
        tick(); expect_idle("R1 masked at reset");
        line(0, 1'b0); tick();

        // R12 / R3: edge pin 1
        set_route(1, 8'h31, 8'h05, 1'b1, 3'd1, 1'b0, 1'b0); tick();
        line(1, 1'b1); tick();
        expect_dlv(8'h31, 8'h05, "R12 edge delivery");
        checks++;
        if (!(dlv_dest_logical === 1'b1 && dlv_dmode === 3'd1 && dlv_level === 1'b0)) begin
            failures++;
            $display("FAIL R12 fields actual lg=%0b dm=%0d lt=%0b expected lg=1 dm=1 lt=0",
                     dlv_dest_logical, dlv_dmode, dlv_level);
        end
        tick(); expect_idle("R10 single edge delivery");
        line(1, 1'b1); tick(); expect_idle("R3 coalesced");
        tick(); expect_idle("R3 coalesced");
        line(1, 1'b0); tick();
        line(1, 1'b1); tick(); expect_dlv(8'h31, 8'h05, "R3 new edge after low");
        tick(); expect_idle("R3 new edge once");
        // R10: EOI and rewrite of an edge entry bring nothing
        send_eoi(8'h31); tick(); expect_idle("R10 eoi on edge");
        tick(); expect_idle("R10 eoi on edge");
        set_route(1, 8'h31, 8'h06, 1'b1, 3'd1, 1'b0, 1'b0); tick(); tick();
        expect_idle("R10 rewrite edge");

        // R4 / R9: level pin 2 masked, then unmasked
        set_route(2, 8'h32, 8'h02, 1'b0, 3'd0, 1'b1, 1'b1); tick();
        line(2, 1'b1); tick(); expect_idle("R4 masked");
        tick(); expect_idle("R4 masked");
        set_route(2, 8'h32, 8'h02, 1'b0, 3'd0, 1'b1, 1'b0);
        tick(); expect_idle("R9 not yet");
        tick(); expect_dlv(8'h32, 8'h02, "R9 unmask delivers");
        tick();
        // R5: remote-IRR holds the pin
        line(2, 1'b1); tick(); expect_idle("R5 remote-IRR blocks");
        tick(); expect_idle("R5 remote-IRR blocks");
        // R7: EOI redelivers
        send_eoi(8'h32); tick(); expect_dlv(8'h32, 8'h02, "R7 eoi redelivery");
        tick();
        // R2: low clears IRR, EOI then brings nothing
        line(2, 1'b0); tick();
        send_eoi(8'h32); tick(); expect_idle("R2 cleared IRR");
        tick(); expect_idle("R2 cleared IRR");
        // R6: refused delivery leaves remote-IRR clear
        line(2, 1'b1); tick(); expect_dlv(8'h32, 8'h02, "R6 first delivery");
        dlv_accepted = 1'b0; tick(); dlv_accepted = 1'b1;
        line(2, 1'b1); tick(); expect_dlv(8'h32, 8'h02, "R6 refused then redelivered");
        tick();
        line(2, 1'b0); tick();
        send_eoi(8'h32); tick(); expect_idle("R6 cleanup");

        // R11 / R8: two level pins sharing one vector
        set_route(3, 8'h44, 8'h03, 1'b0, 3'd0, 1'b1, 1'b0);
        set_route(5, 8'h44, 8'h55, 1'b0, 3'd2, 1'b1, 1'b0);
        tick(); tick();
        line_upd[3] = 1'b1; line_lvl[3] = 1'b1;
        line_upd[5] = 1'b1; line_lvl[5] = 1'b1;
        tick(); line_upd = '0;
        tick(); expect_dlv(8'h44, 8'h03, "R11 lower pin first");
        tick(); expect_dlv(8'h44, 8'h55, "R11 higher pin next");
        tick(); expect_idle("R11 one each");
        send_eoi(8'h44); tick(); expect_dlv(8'h44, 8'h03, "R8 eoi first match");
        tick(); expect_dlv(8'h44, 8'h55, "R8 eoi second match");
        tick(); expect_idle("R8 done");

        // R13: rewrite as edge clears remote-IRR of pin 3
        set_route(3, 8'h44, 8'h03, 1'b0, 3'd0, 1'b0, 1'b0);
        set_route(3, 8'h44, 8'h03, 1'b0, 3'd0, 1'b1, 1'b0);
        tick(); expect_idle("R13 not yet");
        tick(); expect_dlv(8'h44, 8'h03, "R13 pending after edge rewrite");
        tick(); expect_idle("R13 once");
        repeat (3) tick();

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule